// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block drives the two chip-enable levels of a pseudo-static RAM while the memory is powering up, entering deep power-down and coming back out of it. While it holds control, it forces the active-low enable high, sets the active-high enable, and blocks the data output drivers. It passes the enables to the access controller only once the memory is usable. All minimum times are counted in clock cycles. Each one is a parameter, so the block can be retargeted to another clock by changing parameter values.

Power-up has two stages. First the active-high enable is kept low for tens of microseconds. Then it is raised while the active-low enable stays high for hundreds of microseconds. Leaving power-down ends in the same long hold, so a power-down entry followed by a wake also resets the device when the power-up timing could not be met.

A power-down request is accepted only from the ready state, and it waits until the access controller reports idle. A wake request that arrives during entry is remembered and served as soon as the minimum power-down low time has passed. Losing the supply indication returns the block to its off state from anywhere.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is held, and in the off state, ce2_level=0, ce1_force_hi=1, dq_oe_off=1, mem_ready=0 and seq_busy=0.
- R2: Once supply_ok is high in the off state, ce2_level stays low with seq_busy=1 for exactly T_C2L cycles.
- R3: ce2_level then rises with ce1_force_hi held high and mem_ready low for exactly T_CEH cycles before ready.
- R4: In the ready state ce1_force_hi=0, ce2_level=1, dq_oe_off=0, mem_ready=1 and seq_busy=0.
- R5: A one-cycle pd_req seen while acc_busy=1 is held. mem_ready stays 1 until acc_busy goes low, and entry starts on the next clock.
- R6: Entry first forces ce1_force_hi high with ce2_level still high for exactly T_CSP cycles. mem_ready drops in the first cycle of entry.
- R7: ce2_level then stays low for exactly T_C2LP cycles with seq_busy=1. After that, with no wake pending, the block idles in power-down: ce2_level=0, ce1_force_hi=1, dq_oe_off=1, seq_busy=0.
- R8: A wake_req in power-down raises ce2_level on the next clock with ce1_force_hi kept high, runs the T_CEH hold, and then enters ready.
- R9: A wake_req that arrives during entry is queued. The exit hold starts right after the T_C2LP low time, with no idle phase between.
- R10: wake_req outside entry and power-down, and pd_req outside the ready state, change no output.
- R11: supply_ok low in any state puts the block in the off state on the next clock. The full power-up runs again when supply_ok returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply at or above its minimum |
| pd_req | input | 1 | Power-down request (pulse or level) |
| wake_req | input | 1 | Wake request (pulse or level) |
| acc_busy | input | 1 | Access controller has an access in progress |
| ce1_force_hi | output | 1 | Override that forces the active-low enable high |
| ce2_level | output | 1 | Level driven on the active-high enable |
| dq_oe_off | output | 1 | Forces the data output enable off |
| mem_ready | output | 1 | Memory may be accessed by the access controller |
| seq_busy | output | 1 | A timed sequence phase is running |

## Verification
The sequencer is tried along four paths. The first is a plain power-up. The second is a power-down request made while an access is in progress, which shows whether the hold-off waits for idle rather than cutting off an access. The third is a wake issued after the device has settled into power-down. The fourth is a wake issued during the entry setup, which separates a queued exit (no idle phase) from a dropped request. Each phase is compared for both its output levels and its exact length in cycles, so a shortened or stretched wait shows up. Stray requests in the wrong states and a supply loss in the ready state check that the block ignores misplaced inputs and restarts the full power-up.

// File: rtl/psram_seq_pkg.sv
// Shared types for the pseudo-SRAM power sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package psram_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_PWRUP_LOW = 3'd1,
        ST_WAKE_HOLD = 3'd2,
        ST_READY     = 3'd3,
        ST_PD_SETUP  = 3'd4,
        ST_PD_LOW    = 3'd5,
        ST_PD_IDLE   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/psram_seq_timer.sv
// Down-counter shared by every timed phase of the sequencer.
// A load sets the count to (phase length - 1). done is high in the last
// cycle of the phase, so a phase loaded with N-1 lasts exactly N cycles.
// Assumes: the caller loads on the same edge that enters the phase.
module psram_seq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_req_hold.sv
// Remembers a request pulse while arm is high and clears it when clear is high.
// Assumes: arm and clear are never high together (clear wins if they are).
module psram_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic req,
    input  logic clear,
    output logic pend
);

    logic pend_q;

    // capture a request in the armed window, drop it outside
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clear) begin
            pend_q <= 1'b0;
        end else if (arm && req) begin
            pend_q <= 1'b1;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/psram_pwr_seq.sv
// Power-up / power-down sequencer for a pseudo-static RAM.
// Owns both chip-enable levels until the memory is ready, then releases the
// active-low enable to the access controller. Every minimum time is a cycle
// count set by a parameter. Outputs are decoded from the registered state.
// Assumes: supply_ok, pd_req, wake_req and acc_busy are synchronous to clk.
module psram_pwr_seq
    import psram_seq_pkg::*;
#(
    parameter int unsigned T_C2L  = 12500,  // CE2 low after supply good
    parameter int unsigned T_CEH  = 75000,  // CE1 high hold before ready
    parameter int unsigned T_CSP  = 3,      // CE1 high before CE2 falls
    parameter int unsigned T_C2LP = 20      // minimum CE2 low in power-down
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pd_req,
    input  logic wake_req,
    input  logic acc_busy,
    output logic ce1_force_hi,
    output logic ce2_level,
    output logic dq_oe_off,
    output logic mem_ready,
    output logic seq_busy
);

    localparam int unsigned MAX_LONG  = (T_C2L > T_CEH) ? T_C2L : T_CEH;
    localparam int unsigned MAX_SHORT = (T_CSP > T_C2LP) ? T_CSP : T_C2LP;
    localparam int unsigned MAX_ALL   = (MAX_LONG > MAX_SHORT) ? MAX_LONG : MAX_SHORT;
    localparam int unsigned CW        = $clog2(MAX_ALL + 1);

    seq_state_t    state_q, state_d;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val;
    logic          pd_pend, wake_pend;
    logic          pd_arm, wake_arm;

    assign pd_arm   = (state_q == ST_READY);
    assign wake_arm = (state_q == ST_PD_SETUP) || (state_q == ST_PD_LOW);

    psram_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_req_hold u_pd_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (pd_arm),
        .req   (pd_req),
        .clear (!pd_arm),
        .pend  (pd_pend)
    );

    psram_req_hold u_wake_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (wake_arm),
        .req   (wake_req),
        .clear (!wake_arm),
        .pend  (wake_pend)
    );

    // next-state selection; supply loss overrides every state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:       if (supply_ok) state_d = ST_PWRUP_LOW;
            ST_PWRUP_LOW: if (tmr_done) state_d = ST_WAKE_HOLD;
            ST_WAKE_HOLD: if (tmr_done) state_d = ST_READY;
            ST_READY:     if ((pd_req || pd_pend) && !acc_busy) state_d = ST_PD_SETUP;
            ST_PD_SETUP:  if (tmr_done) state_d = ST_PD_LOW;
            ST_PD_LOW:    if (tmr_done) state_d = (wake_req || wake_pend) ? ST_WAKE_HOLD : ST_PD_IDLE;
            ST_PD_IDLE:   if (wake_req) state_d = ST_WAKE_HOLD;
            default:      state_d = ST_OFF;
        endcase
        if (!supply_ok) state_d = ST_OFF;
    end

    // timer reload value for the phase being entered
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_PWRUP_LOW: tmr_val = CW'(T_C2L - 1);
            ST_WAKE_HOLD: tmr_val = CW'(T_CEH - 1);
            ST_PD_SETUP:  tmr_val = CW'(T_CSP - 1);
            ST_PD_LOW:    tmr_val = CW'(T_C2LP - 1);
            default:      tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // pin-level decode of the registered state
    always_comb begin
        ce1_force_hi = (state_q != ST_READY);
        dq_oe_off    = (state_q != ST_READY);
        mem_ready    = (state_q == ST_READY);
        ce2_level    = (state_q == ST_WAKE_HOLD) || (state_q == ST_READY) ||
                       (state_q == ST_PD_SETUP);
        seq_busy     = (state_q == ST_PWRUP_LOW) || (state_q == ST_WAKE_HOLD) ||
                       (state_q == ST_PD_SETUP)  || (state_q == ST_PD_LOW);
    end

endmodule

// File: rtl/psram_pwr_seq_chk.sv
// Property checker for psram_pwr_seq, attached by bind below.
// Assumes: the same parameter values as the bound instance.
module psram_pwr_seq_chk #(
    parameter int unsigned T_C2L  = 12500,
    parameter int unsigned T_C2LP = 20
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic acc_busy,
    input logic ce1_force_hi,
    input logic ce2_level,
    input logic dq_oe_off,
    input logic mem_ready
);

    localparam int unsigned LOW_MIN = (T_C2L < T_C2LP) ? T_C2L : T_C2LP;
    localparam int unsigned LW      = $clog2(LOW_MIN + 1);

    logic [LW-1:0] low_cnt;

    // saturating count of consecutive cycles with CE2 low
    always_ff @(posedge clk) begin
        if (!rst_n)                     low_cnt <= '0;
        else if (ce2_level)             low_cnt <= '0;
        else if (low_cnt < LW'(LOW_MIN)) low_cnt <= low_cnt + 1'b1;
    end

    AST_READY_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ready |-> (ce2_level && !ce1_force_hi && !dq_oe_off)); // R4

    AST_READY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ready) |-> ($past(ce1_force_hi) && $past(ce2_level))); // R3

    AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!ce2_level && !mem_ready)); // R11

    AST_BUSY_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ready && acc_busy && supply_ok) |=> mem_ready); // R5

    AST_CE2_FALL_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ce2_level) && $past(supply_ok)) |-> $past(ce1_force_hi)); // R6

    AST_PD_DQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ce2_level |-> (dq_oe_off && ce1_force_hi)); // R7

    AST_CE2_LOW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce2_level) |-> (low_cnt >= LW'(LOW_MIN))); // R7

endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
    .T_C2L  (T_C2L),
    .T_C2LP (T_C2LP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .acc_busy     (acc_busy),
    .ce1_force_hi (ce1_force_hi),
    .ce2_level    (ce2_level),
    .dq_oe_off    (dq_oe_off),
    .mem_ready    (mem_ready)
);

// File: tb/psram_pwr_seq_tb.sv
// Scoreboard bench: the driver queues expected phases (output vector plus
// exact length), the monitor pops one on every output change and compares.
// Output vector order: {ce1_force_hi, ce2_level, mem_ready, seq_busy, dq_oe_off}
module psram_pwr_seq_tb;

    localparam int unsigned P_C2L  = 10;
    localparam int unsigned P_CEH  = 20;
    localparam int unsigned P_CSP  = 3;
    localparam int unsigned P_C2LP = 6;

    localparam logic [4:0] V_OFF   = 5'b10001;
    localparam logic [4:0] V_C2L   = 5'b10011;
    localparam logic [4:0] V_HOLD  = 5'b11011;
    localparam logic [4:0] V_READY = 5'b01100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, pd_req = 1'b0, wake_req = 1'b0, acc_busy = 1'b0;
    logic ce1_force_hi, ce2_level, dq_oe_off, mem_ready, seq_busy;
    logic [4:0] outs;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [4:0] q_vec[$];
    int         q_len[$];
    int         q_req[$];

    always #2 clk = ~clk;  // 250 MHz

    psram_pwr_seq #(
        .T_C2L(P_C2L), .T_CEH(P_CEH), .T_CSP(P_CSP), .T_C2LP(P_C2LP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pd_req(pd_req),
        .wake_req(wake_req), .acc_busy(acc_busy), .ce1_force_hi(ce1_force_hi),
        .ce2_level(ce2_level), .dq_oe_off(dq_oe_off), .mem_ready(mem_ready),
        .seq_busy(seq_busy)
    );

    assign outs = {ce1_force_hi, ce2_level, mem_ready, seq_busy, dq_oe_off};

    task automatic check(input bit ok, input int req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_phase(input logic [4:0] v, input int len, input int req);
        q_vec.push_back(v);
        q_len.push_back(len);
        q_req.push_back(req);
    endtask

    task automatic wait_ready();
        do @(negedge clk); while (!mem_ready);
    endtask

    // monitor: phase boundaries, vectors and lengths
    logic [4:0] last_v;
    int run_len = 0;
    int cur_len = 0;
    int cur_req = 0;
    bit started = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (!started || outs != last_v) begin
                if (started && cur_len != 0)
                    check(run_len == cur_len, cur_req, run_len, cur_len, "phase length");
                if (q_vec.size() == 0) begin
                    check(1'b0, 10, int'(outs), int'(last_v), "unexpected output change");
                    cur_len = 0;
                end else begin
                    automatic logic [4:0] ev = q_vec.pop_front();
                    cur_len = q_len.pop_front();
                    cur_req = q_req.pop_front();
                    check(outs == ev, cur_req, int'(outs), int'(ev), "phase vector");
                end
                started = 1'b1;
                run_len = 1;
            end else begin
                run_len++;
            end
            last_v = outs;
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, 0, 0, 1, "watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // driver
    initial begin
        repeat (3) @(negedge clk);
        check(outs == V_OFF, 1, int'(outs), int'(V_OFF), "reset state"); // R1
        expect_phase(V_OFF, 0, 1);                 // R1 off after release
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // power-up: R2 then R3 then R4
        expect_phase(V_C2L, P_C2L, 2);
        expect_phase(V_HOLD, P_CEH, 3);
        expect_phase(V_READY, 0, 4);
        supply_ok = 1'b1;
        wait_ready();
        repeat (3) @(negedge clk);

        // R10: stray wake in ready is ignored
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        repeat (5) @(negedge clk);
        check(outs == V_READY, 10, int'(outs), int'(V_READY), "wake in ready ignored");

        // R5: request during an access is held off
        acc_busy = 1'b1;
        pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
        repeat (6) @(negedge clk);
        check(mem_ready == 1'b1, 5, int'(mem_ready), 1, "ready held while access busy");
        expect_phase(V_HOLD, P_CSP, 6);            // R6 entry setup
        expect_phase(V_C2L, P_C2LP, 7);            // R7 CE2 low window
        expect_phase(V_OFF, 0, 7);                 // R7 power-down idle
        acc_busy = 1'b0;
        @(negedge clk);
        check(mem_ready == 1'b0, 6, int'(mem_ready), 0, "ready drops on first entry cycle");
        repeat (P_CSP + P_C2LP + 10) @(negedge clk);
        check(outs == V_OFF, 7, int'(outs), int'(V_OFF), "power-down idle pins");

        // R10: pd_req in power-down is ignored
        pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
        repeat (4) @(negedge clk);
        check(outs == V_OFF, 10, int'(outs), int'(V_OFF), "pd_req in power-down ignored");

        // R8: wake from power-down
        expect_phase(V_HOLD, P_CEH, 8);
        expect_phase(V_READY, 0, 8);
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        check(ce2_level == 1'b1 && ce1_force_hi == 1'b1, 8, int'(outs), int'(V_HOLD), "exit raises CE2 with CE1 high");
        wait_ready();
        repeat (3) @(negedge clk);

        // R9: wake during entry is queued
        expect_phase(V_HOLD, P_CSP, 6);
        expect_phase(V_C2L, P_C2LP, 7);
        expect_phase(V_HOLD, P_CEH, 9);
        expect_phase(V_READY, 0, 9);
        pd_req = 1'b1; @(negedge clk); pd_req = 1'b0;
        check(seq_busy == 1'b1, 6, int'(seq_busy), 1, "entry started");
        wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
        wait_ready();
        repeat (3) @(negedge clk);

        // R11: supply loss from ready, then full power-up again
        expect_phase(V_OFF, 0, 11);
        supply_ok = 1'b0;
        @(negedge clk);
        check(outs == V_OFF, 11, int'(outs), int'(V_OFF), "supply loss to off");
        repeat (3) @(negedge clk);
        expect_phase(V_C2L, P_C2L, 11);
        expect_phase(V_HOLD, P_CEH, 11);
        expect_phase(V_READY, 0, 11);
        supply_ok = 1'b1;
        wait_ready();
        repeat (4) @(negedge clk);

        check(q_vec.size() == 0, 4, q_vec.size(), 0, "all expected phases seen");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule